// File: doc/BRIEF.md
# MDIO Bus Master Controller

This block turns management requests into complete serial management frames on a two-wire PHY management bus. A request carries a 2-bit opcode, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The request is taken over a valid/ready handshake. The controller divides its system clock down to produce the management clock (MDC). It drives the shared data line through separate output and output-enable pins, and it sends one 64-bit frame per request.

For a read, the controller stops driving the line for the turnaround and data fields. It shifts in the 16 bits returned by the PHY and presents them on a valid/ready response port. Only one transaction is in flight at a time. A new request is refused until the current frame has finished and, for a read, until its response has been taken.

Top module: `mdio_master`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mdio_oe` is 0 and `mdc` is 1.
- R2: While a frame is running, MDC has a period of CLK_HZ/MDC_HZ system clocks, with half of that period low and half high.
- R3: A frame is 64 MDC cycles sent most significant bit first, in this order: 32 ones, start 01, opcode, PHY address, register address, a 2-bit turnaround, then 16 data bits.
- R4: For any opcode other than 10 (write is 01), the turnaround is driven as 10, the data field carries the request's write data, and `mdio_oe` is 1 for all 64 bits.
- R5: For the read opcode 10, `mdio_oe` is 1 for bits 0 to 45 (counted from the first preamble bit) and 0 for bits 46 to 63.
- R6: `mdio_o` and `mdio_oe` change only at a falling edge of MDC, or in the single system clock that ends a frame, which is while MDC is high. They are never changed while MDC is high at any other time.
- R7: On a read, `mdio_i` is sampled at the MDC rising edges of bits 48 to 63 and shifted in MSB first, so the bit at position 48 becomes `rsp_rdata[15]`.
- R8: `req_ready` is 0 from acceptance until one system clock after the last rising MDC edge of the frame. Request inputs that change after acceptance do not alter the frame.
- R9: `rsp_valid` stays 1 with unchanged `rsp_rdata` until `rsp_ready` is seen. While it is 1, no request is accepted.
- R10: With IDLE_MDC_RUN = 0, MDC is held high and `mdio_oe` is 0 while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The controller can take a request |
| req_op | input | 2 | Opcode: 10 read, 01 write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data is available |
| rsp_ready | input | 1 | The consumer takes the read data |
| rsp_rdata | output | 16 | Captured read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A wrong bit counter shows up within one frame as misplaced fields in the captured 64-bit pattern, or as an output-enable window shifted off bits 46 to 63. It also shows up as `req_ready` returning early or late relative to the 64th rising MDC edge. A divider fault shows up on the very next MDC low phase as a wrong period. A capture or response-state fault appears as a wrong or unstable `rsp_rdata` on the first read, which is held under back-pressure to expose it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int OP_W       = 2;

    localparam logic [OP_W-1:0] OP_READ   = 2'b10;
    localparam logic [OP_W-1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0]      START_SEQ = 2'b01;
    localparam logic [1:0]      TURN_WR   = 2'b10;

    // bit positions within the frame, counted from the first preamble bit
    localparam logic [5:0] IDX_TURN = 6'd46;
    localparam logic [5:0] IDX_DATA = 6'd48;
    localparam logic [5:0] IDX_LAST = 6'd63;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_HOLD,
        ST_RESP
    } mdio_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
        return {32'hFFFF_FFFF, START_SEQ, r.op, r.phy, r.regad, TURN_WR, r.wdata};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF         = 20,
    parameter bit IDLE_MDC_RUN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CNT_W = $clog2(HALF) + 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t gen_d, gen_q;
    logic tick;

    always_comb begin
        gen_d = gen_q;
        tick  = 1'b0;
        if (!run && !IDLE_MDC_RUN && gen_q.mdc) begin
            gen_d.cnt = '0;
        end else if (gen_q.cnt == CNT_TOP) begin
            gen_d.cnt = '0;
            gen_d.mdc = ~gen_q.mdc;
            tick      = 1'b1;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.cnt <= '0;
            gen_q.mdc <= 1'b1;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign mdc      = gen_q.mdc;
    assign rise_stb = tick & ~gen_q.mdc;
    assign fall_stb = tick &  gen_q.mdc;

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] data
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear) begin
            sh_d = '0;
        end else if (shift_en) begin
            sh_d = {sh_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign data = sh_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int MDC_HZ       = 2_500_000,
    parameter bit IDLE_MDC_RUN = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [15:0] rsp_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int RATIO = CLK_HZ / MDC_HZ;
    localparam int HALF  = (RATIO / 2 < 2) ? 2 : RATIO / 2;

    typedef struct packed {
        mdio_state_e state;
        mdio_req_t   req;
        logic [5:0]  idx;
        logic        started;
        logic        out;
        logic        oe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  run;
    logic                  rise_stb;
    logic                  fall_stb;
    logic                  cap_clr;
    logic                  cap_en;
    logic                  is_rd;
    logic [5:0]            nxt_idx;
    logic [FRAME_BITS-1:0] frame;

    mdio_mdc_gen #(
        .HALF         (HALF),
        .IDLE_MDC_RUN (IDLE_MDC_RUN)
    ) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_rx_shift #(
        .W (DATA_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cap_clr),
        .shift_en (cap_en),
        .din      (mdio_i),
        .data     (rsp_rdata)
    );

    always_comb begin
        ctl_d   = ctl_q;
        cap_clr = 1'b0;
        cap_en  = 1'b0;
        run     = (ctl_q.state == ST_FRAME);
        is_rd   = (ctl_q.req.op == OP_READ);
        frame   = build_frame(ctl_q.req);
        nxt_idx = ctl_q.started ? ctl_q.idx + 6'd1 : 6'd0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.state     = ST_FRAME;
                    ctl_d.req.op    = req_op;
                    ctl_d.req.phy   = req_phy;
                    ctl_d.req.regad = req_reg;
                    ctl_d.req.wdata = req_wdata;
                    ctl_d.idx       = '0;
                    ctl_d.started   = 1'b0;
                    cap_clr         = 1'b1;
                end
            end
            ST_FRAME: begin
                if (fall_stb) begin
                    ctl_d.idx     = nxt_idx;
                    ctl_d.started = 1'b1;
                    ctl_d.out     = frame[IDX_LAST - nxt_idx];
                    ctl_d.oe      = !(is_rd && (nxt_idx >= IDX_TURN));
                end else if (rise_stb && ctl_q.started) begin
                    cap_en = is_rd && (ctl_q.idx >= IDX_DATA);
                    if (ctl_q.idx == IDX_LAST) begin
                        ctl_d.state = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                ctl_d.oe    = 1'b0;
                ctl_d.out   = 1'b1;
                ctl_d.state = is_rd ? ST_RESP : ST_IDLE;
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.req     <= '0;
            ctl_q.idx     <= '0;
            ctl_q.started <= 1'b0;
            ctl_q.out     <= 1'b1;
            ctl_q.oe      <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.state == ST_IDLE);
    assign rsp_valid = (ctl_q.state == ST_RESP);
    assign mdio_o    = ctl_q.out;
    assign mdio_oe   = ctl_q.oe;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int CLK_HZ       = 100_000_000,
    parameter int MDC_HZ       = 2_500_000,
    parameter bit IDLE_MDC_RUN = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [15:0] rsp_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    localparam int RATIO = CLK_HZ / MDC_HZ;
    localparam int HALF  = (RATIO / 2 < 2) ? 2 : RATIO / 2;

    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (!mdc) begin
            low_cnt <= low_cnt + 1;
        end else begin
            low_cnt <= 0;
        end
    end

    // R2
    mdc_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> (low_cnt == HALF));

    // R6
    out_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc) && !req_ready && !$rose(req_ready) && !$rose(rsp_valid))
        |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8
    busy_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> !req_ready);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

    // R9
    no_accept_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mdio_oe);

    if (!IDLE_MDC_RUN) begin : g_idle_hold
        // R10
        idle_mdc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ready && $past(req_ready)) |-> mdc);
    end

endmodule

bind mdio_master mdio_master_chk #(
    .CLK_HZ       (CLK_HZ),
    .MDC_HZ       (MDC_HZ),
    .IDLE_MDC_RUN (IDLE_MDC_RUN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    localparam int CLK_HZ = 50_000_000;
    localparam int MDC_HZ = 5_000_000;
    localparam int DIV    = CLK_HZ / MDC_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [15:0] rsp_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    always #4 clk = ~clk;

    mdio_master #(.CLK_HZ(CLK_HZ), .MDC_HZ(MDC_HZ), .IDLE_MDC_RUN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] exp_frame_q[$];
    logic [63:0] exp_oe_q[$];
    logic [15:0] exp_rd_q[$];

    bit          in_frame = 1'b0;
    int          rcnt = 0;
    int          since_rise = 0;
    bit          period_ok = 1'b1;
    bit          ready_ok = 1'b1;
    logic        prev_mdc = 1'b1;
    logic        low_o = 1'b1;
    logic        low_oe = 1'b0;
    logic [63:0] got_bits = '0;
    logic [63:0] got_oe = '0;
    logic [15:0] phy_data = '0;
    bit          phy_rd = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // PHY model: returns read data during bits 48..63
    always_comb begin
        if (phy_rd && in_frame && rcnt >= 48 && rcnt < 64) mdio_i = phy_data[63 - rcnt];
        else mdio_i = 1'b1;
    end

    // frame monitor: records the value held during each MDC low phase at the following rise
    always @(negedge clk) begin
        if (in_frame) begin
            since_rise++;
            if (!mdc) begin
                low_o  = mdio_o;
                low_oe = mdio_oe;
            end else if (!prev_mdc) begin
                got_bits[63 - rcnt] = low_o;
                got_oe[63 - rcnt]   = low_oe;
                if (rcnt > 0 && since_rise != DIV) period_ok = 1'b0;
                if (req_ready) ready_ok = 1'b0;
                since_rise = 0;
                rcnt++;
                if (rcnt == 64) begin
                    logic [63:0] ef, eo;
                    ef = exp_frame_q.pop_front();
                    eo = exp_oe_q.pop_front();
                    check((got_bits & eo) == (ef & eo), "R3 frame bits", got_bits & eo, ef & eo);
                    check(got_oe == eo, (eo[0] ? "R4 drive window" : "R5 drive window"), got_oe, eo);
                    check(period_ok, "R2 MDC period", 64'(period_ok), 64'd1);
                    check(ready_ok, "R8 ready low in frame", 64'(ready_ok), 64'd1);
                    in_frame = 1'b0;
                end
            end
        end
        prev_mdc = mdc;
    end

    // response monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            logic [15:0] er;
            er = exp_rd_q.pop_front();
            check(rsp_rdata == er, "R7 read data", 64'(rsp_rdata), 64'(er));
        end
    end

    task automatic send(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input logic [15:0] rd);
        do @(negedge clk); while (!req_ready);
        phy_data = rd;
        phy_rd   = (op == 2'b10);
        exp_frame_q.push_back({32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, wd});
        exp_oe_q.push_back(phy_rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF);
        if (phy_rd) exp_rd_q.push_back(rd);
        req_valid = 1'b1;
        req_op    = op;
        req_phy   = phy;
        req_reg   = rg;
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid  = 1'b0;
        // R8: scrambled inputs after acceptance must not reach the frame
        req_op     = ~op;
        req_phy    = ~phy;
        req_reg    = ~rg;
        req_wdata  = ~wd;
        rcnt       = 0;
        since_rise = 0;
        period_ok  = 1'b1;
        ready_ok   = 1'b1;
        prev_mdc   = mdc;
        in_frame   = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit hold_ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check(mdio_oe == 1'b0, "R1 reset oe", 64'(mdio_oe), 64'd0);
        check(mdc == 1'b1, "R1 reset mdc", 64'(mdc), 64'd1);

        send(2'b01, 5'h01, 5'h02, 16'hA5C3, 16'h0000);
        send(2'b10, 5'h1F, 5'h00, 16'h1234, 16'h3C5A);
        send(2'b01, 5'h00, 5'h1F, 16'h0000, 16'h0000);
        send(2'b10, 5'h0A, 5'h15, 16'h0000, 16'hFFFF);
        send(2'b11, 5'h15, 5'h0A, 16'h8001, 16'h0000);

        // R9: back-pressure on the response
        rsp_ready = 1'b0;
        send(2'b10, 5'h11, 5'h0E, 16'hFFFF, 16'h0001);
        do @(negedge clk); while (!rsp_valid);
        repeat (20) @(negedge clk);
        check(rsp_valid == 1'b1, "R9 valid held", 64'(rsp_valid), 64'd1);
        check(req_ready == 1'b0, "R9 no accept", 64'(req_ready), 64'd0);
        check(rsp_rdata == 16'h0001, "R9 data held", 64'(rsp_rdata), 64'h0001);
        rsp_ready = 1'b1;

        send(2'b10, 5'h03, 5'h07, 16'h0000, 16'h8000);
        do @(negedge clk); while (!req_ready);

        // R10: idle keeps MDC high and line released
        hold_ok = 1'b1;
        for (int i = 0; i < 3 * DIV; i++) begin
            @(negedge clk);
            if (mdc !== 1'b1 || mdio_oe !== 1'b0) hold_ok = 1'b0;
        end
        check(hold_ok, "R10 idle hold", 64'(hold_ok), 64'd1);
        check(exp_rd_q.size() == 0, "R7 responses drained", 64'(exp_rd_q.size()), 64'd0);
        check(exp_frame_q.size() == 0, "R3 frames drained", 64'(exp_frame_q.size()), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule